// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a small synchronous up-counter that can be preset to any value from a parallel data bus. It has two separate count qualifiers and a terminal-count output, so several copies can be chained into a wider counter. All register updates happen together on the rising clock edge, so the outputs never pass through intermediate values between two counts.

Two enables must both be high for the counter to advance. Only the chain enable also qualifies the terminal-count output. When stages are chained, each stage's terminal-count output drives the next stage's chain enable. The clock and the local count enable go to every stage. The clear input is active low. A parameter decides whether clear takes effect at once or at the next clock edge. In the clock-edge form, an external decode of a chosen count can be fed back to the clear input to shorten the count length, with no glitch on the outputs.

Top module: `presettable_counter`

## Requirements
- R1: With ASYNC_CLEAR=1, a low on `clear_n` forces `value` to 0 at once, without waiting for a clock edge and whatever the levels of `preset_n`, `cnt_en` and `chain_en`.
- R2: With ASYNC_CLEAR=0, a low on `clear_n` leaves `value` unchanged until the next rising edge of `clk`. At that edge `value` becomes 0, whatever the enable levels.
- R3: While `clear_n` is high, a low on `preset_n` at a rising edge copies `preset_val` into `value`, whatever the levels of `cnt_en` and `chain_en`.
- R4: While `clear_n` and `preset_n` are high, `value` goes up by one at a rising edge only when `cnt_en` and `chain_en` are both 1. In every other case `value` holds.
- R5: An increment from the all-ones value (15 for WIDTH=4) wraps `value` to 0.
- R6: `tc_out` is 1 exactly when `value` is all ones and `chain_en` is 1. It does not depend on `cnt_en`.
- R7: The order of priority is clear, then preset, then count, then hold.
- R8: Changes on `preset_n`, `cnt_en` or `chain_en` between two rising edges do not change `value` before the next edge.
- R9: In a two-stage chain, the low stage's `tc_out` drives the high stage's `chain_en`, and both stages share `clk` and `cnt_en`. The pair counts 0 to 255 in order and then wraps to 0.
- R10: With ASYNC_CLEAR=0, feeding the decode of `value == 9` back into `clear_n` gives a counter that repeats the sequence 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Active-low clear; the ASYNC_CLEAR parameter sets whether it acts at once or at the next edge |
| preset_n | input | 1 | Active-low parallel preset |
| cnt_en | input | 1 | Local count enable; it does not affect `tc_out` |
| chain_en | input | 1 | Chain count enable; it also qualifies `tc_out` |
| preset_val | input | WIDTH | Value loaded on preset |
| value | output | WIDTH | Current count |
| tc_out | output | 1 | Terminal count: `value` is all ones and `chain_en` is high |

## Verification
The hardest situations to reach from the ports involve timing within a clock cycle. The first is an immediate clear arriving between two edges, which must be told apart from the clock-edge clear. The second is a control pulse that starts and ends between edges, which must leave the count untouched. The bench drives one stimulus into a clock-edge instance and an immediate-clear instance side by side. It lowers clear part-way through a cycle and samples both outputs before the next edge. It also pulses preset and the count enable off and back on again inside a single cycle. A full sweep over every preset value and every enable combination covers wrap and terminal count. A chained pair and a clear-feedback divide-by-ten instance cover the two system-level uses.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_t;

endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    clear_n,
  input  logic    preset_n,
  input  logic    cnt_en,
  input  logic    chain_en,
  output cnt_op_t op
);

  always_comb begin
    if (!clear_n)                op = OP_CLEAR;
    else if (!preset_n)          op = OP_LOAD;
    else if (cnt_en && chain_en) op = OP_COUNT;
    else                         op = OP_HOLD;
  end

endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_op_t          op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] nxt
);

  logic [WIDTH:0]   ones_below;
  logic [WIDTH-1:0] inc;

  assign ones_below[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign ones_below[i+1] = ones_below[i] & cur[i];
    assign inc[i]          = cur[i] ^ ones_below[i];
  end

  logic unused_top;
  assign unused_top = ones_below[WIDTH];

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = load_val;
      OP_COUNT: nxt = inc;
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/cnt_state.sv
module cnt_state #(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);

  if (ASYNC_CLEAR) begin : g_async
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) q <= '0;
      else         q <= nxt;
    end
  end else begin : g_sync
    logic unused_arst;
    assign unused_arst = arst_n;
    always_ff @(posedge clk) begin
      q <= nxt;
    end
  end

endmodule

// File: rtl/cnt_tc.sv
module cnt_tc #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             chain_en,
  output logic             tc
);

  logic [WIDTH:0] all_hi;
  assign all_hi[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_and
    assign all_hi[i+1] = all_hi[i] & cur[i];
  end

  assign tc = all_hi[WIDTH] & chain_en;

endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             preset_n,
  input  logic             cnt_en,
  input  logic             chain_en,
  input  logic [WIDTH-1:0] preset_val,
  output logic [WIDTH-1:0] value,
  output logic             tc_out
);

  cnt_op_t          op;
  logic [WIDTH-1:0] nxt;

  cnt_ctrl u_ctrl (
    .clear_n  (clear_n),
    .preset_n (preset_n),
    .cnt_en   (cnt_en),
    .chain_en (chain_en),
    .op       (op)
  );

  cnt_next #(.WIDTH(WIDTH)) u_next (
    .op       (op),
    .cur      (value),
    .load_val (preset_val),
    .nxt      (nxt)
  );

  cnt_state #(.WIDTH(WIDTH), .ASYNC_CLEAR(ASYNC_CLEAR)) u_state (
    .clk    (clk),
    .arst_n (clear_n),
    .nxt    (nxt),
    .q      (value)
  );

  cnt_tc #(.WIDTH(WIDTH)) u_tc (
    .cur      (value),
    .chain_en (chain_en),
    .tc       (tc_out)
  );

endmodule

// File: rtl/presettable_counter_checks.sv
module presettable_counter_checks #(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input logic             clk,
  input logic             clear_n,
  input logic             preset_n,
  input logic             cnt_en,
  input logic             chain_en,
  input logic [WIDTH-1:0] preset_val,
  input logic [WIDTH-1:0] value,
  input logic             tc_out
);

  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (!clear_n) armed <= 1'b1;
  end

  // R3
  assert_preset_R3: assert property (@(posedge clk) disable iff (!clear_n || !armed)
    !preset_n |=> value == $past(preset_val));

  // R4
  assert_count_R4: assert property (@(posedge clk) disable iff (!clear_n || !armed)
    (preset_n && cnt_en && chain_en) |=> value == $past(value) + 1'b1);

  // R4, R8
  assert_hold_R4: assert property (@(posedge clk) disable iff (!clear_n || !armed)
    (preset_n && !(cnt_en && chain_en)) |=> $stable(value));

  // R5
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!clear_n || !armed)
    (preset_n && cnt_en && chain_en && value == TOP) |=> value == '0);

  // R6
  assert_tc_set_R6: assert property (@(posedge clk) disable iff (!armed)
    tc_out |-> (chain_en && value == TOP));
  assert_tc_need_R6: assert property (@(posedge clk) disable iff (!armed)
    (chain_en && value == TOP) |-> tc_out);

  if (ASYNC_CLEAR) begin : g_async_chk
    // R1
    assert_async_clear_R1: assert property (@(posedge clk) disable iff (!armed)
      !clear_n |-> value == '0);
  end else begin : g_sync_chk
    // R2, R7
    assert_sync_clear_R2: assert property (@(posedge clk) disable iff (!armed)
      !clear_n |=> value == '0);
  end

endmodule

bind presettable_counter presettable_counter_checks #(
  .WIDTH(WIDTH), .ASYNC_CLEAR(ASYNC_CLEAR)
) u_checks (
  .clk(clk), .clear_n(clear_n), .preset_n(preset_n), .cnt_en(cnt_en),
  .chain_en(chain_en), .preset_val(preset_val), .value(value), .tc_out(tc_out)
);

// File: tb/presettable_counter_test.sv
module presettable_counter_test;

  localparam int PERIOD = 10;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  int tests  = 0;
  int failed = 0;

  // shared stimulus for the clock-edge-clear and immediate-clear instances
  logic       clear_n = 1'b0, preset_n = 1'b1, cnt_en = 1'b0, chain_en = 1'b0;
  logic [3:0] preset_val = 4'd0;
  logic [3:0] s_val, a_val;
  logic       s_tc, a_tc;

  presettable_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) uut (
    .clk(clk), .clear_n(clear_n), .preset_n(preset_n), .cnt_en(cnt_en),
    .chain_en(chain_en), .preset_val(preset_val), .value(s_val), .tc_out(s_tc));

  presettable_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) uut_async (
    .clk(clk), .clear_n(clear_n), .preset_n(preset_n), .cnt_en(cnt_en),
    .chain_en(chain_en), .preset_val(preset_val), .value(a_val), .tc_out(a_tc));

  // two-stage chain
  logic       k_clear_n = 1'b0, k_en = 1'b0;
  logic [3:0] lo_val, hi_val;
  logic       lo_tc, hi_tc;

  presettable_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) stage_lo (
    .clk(clk), .clear_n(k_clear_n), .preset_n(1'b1), .cnt_en(k_en),
    .chain_en(1'b1), .preset_val(4'd0), .value(lo_val), .tc_out(lo_tc));

  presettable_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) stage_hi (
    .clk(clk), .clear_n(k_clear_n), .preset_n(1'b1), .cnt_en(k_en),
    .chain_en(lo_tc), .preset_val(4'd0), .value(hi_val), .tc_out(hi_tc));

  // divide-by-ten through clear feedback
  logic       m_run_n = 1'b0;
  logic [3:0] m_val;
  logic       m_tc;
  logic       m_clear_n;
  assign m_clear_n = m_run_n & (m_val != 4'd9);

  presettable_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) mod10 (
    .clk(clk), .clear_n(m_clear_n), .preset_n(1'b1), .cnt_en(1'b1),
    .chain_en(1'b1), .preset_val(4'd0), .value(m_val), .tc_out(m_tc));

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick();
    check("R2 reset sync", s_val, 0);
    check("R1 reset async", a_val, 0);
    check("R6 tc after reset", s_tc, 0);
    clear_n = 1'b1;

    // sweep: every preset value under every enable combination
    for (int v = 0; v < 16; v++) begin
      for (int e = 0; e < 4; e++) begin
        preset_n   = 1'b0;
        preset_val = 4'(v);
        cnt_en     = e[0];
        chain_en   = e[1];
        tick();
        check("R3 preset sync", s_val, v);
        check("R3 preset async", a_val, v);
        preset_n = 1'b1;
        #1;
        check("R6 tc", s_tc, (v == 15 && e[1]) ? 1 : 0);
        check("R6 tc async", a_tc, (v == 15 && e[1]) ? 1 : 0);
        tick();
        check((v == 15) ? "R5 wrap" : "R4 count/hold", s_val,
              (e == 3) ? ((v + 1) % 16) : v);
        check("R4 count/hold async", a_val, (e == 3) ? ((v + 1) % 16) : v);
      end
    end

    // clear arriving part-way through a cycle
    preset_n = 1'b0; preset_val = 4'd9; cnt_en = 1'b0; chain_en = 1'b0;
    tick();
    preset_n = 1'b1;
    #2 clear_n = 1'b0;
    #1;
    check("R1 immediate clear", a_val, 0);
    check("R2 no clear before edge", s_val, 9);
    tick();
    check("R2 clear at edge", s_val, 0);
    clear_n = 1'b1;

    // priority
    preset_n = 1'b0; preset_val = 4'd7;
    tick();
    clear_n = 1'b0; preset_n = 1'b0; preset_val = 4'd5; cnt_en = 1'b1; chain_en = 1'b1;
    #1;
    check("R2 hold before edge", s_val, 7);
    check("R1 clear over preset", a_val, 0);
    tick();
    check("R7 clear over preset", s_val, 0);
    clear_n = 1'b1;
    tick();
    check("R7 preset over count", s_val, 5);
    check("R7 preset over count async", a_val, 5);

    // control pulses between edges
    preset_n = 1'b1;
    #1 preset_n = 1'b0; preset_val = 4'd12;
    #1 preset_n = 1'b1; cnt_en = 1'b0;
    #1 chain_en = 1'b0;
    #1 chain_en = 1'b1; cnt_en = 1'b1;
    check("R8 no change between edges", s_val, 5);
    tick();
    check("R8 count at edge", s_val, 6);

    // two-stage chain
    tick();
    k_clear_n = 1'b1; k_en = 1'b1;
    for (int i = 0; i < 256; i++) begin
      check("R9 chain value", {hi_val, lo_val}, i);
      check("R9 low stage tc", lo_tc, (i % 16 == 15) ? 1 : 0);
      tick();
    end
    check("R9 chain wrap", {hi_val, lo_val}, 0);
    k_en = 1'b0;
    tick();
    check("R9 chain hold", {hi_val, lo_val}, 0);

    // divide-by-ten
    tick();
    m_run_n = 1'b1;
    for (int i = 0; i < 25; i++) begin
      check("R10 modulo ten", m_val, i % 10);
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule